// File: doc/BRIEF.md
# Dual-Port Mailbox Register Pair

This block carries single words between two independently clocked ports without going through a FIFO. Port A posts a word into the first mail register, and Port B collects it. Port B posts into the second mail register, and Port A collects it. Each register has a flag on its reading side. The flag is active low: LOW means a word is waiting, HIGH means the register is free.

Each port has four controls, all sampled on the rising edge of that port's clock:
- an active-low select,
- a direction bit (1 = write, 0 = read),
- an enable,
- a mailbox-select line.

An access counts only when all four are active.

A shared two-bit bus-size setting limits the usable part of the 36-bit word to its lower lanes:
- `2'b00`: all 36 bits.
- `2'b01`: bits 0 to 17.
- `2'b10` or `2'b11`: bits 0 to 8.

On input, the unused lanes are ignored. On output, they are driven to zero. The byte-order input has no effect on mailbox traffic.

Top module: `mbox_pair`

## Requirements
- R1: After reset, both flags are HIGH and both data outputs are zero.
- R2: A write accepted on one port's rising clock edge drives the other port's flag LOW right after that edge.
- R3: A read happens only when select is LOW, direction is 0, enable is HIGH and mailbox-select is HIGH. It puts the register on the reader's output after that edge and sets the reader's flag HIGH. If any qualifier is inactive, the output and the flag stay unchanged.
- R4: While the reader's flag is LOW, a further write to that register is ignored, so the first word is kept.
- R5: A read leaves the register contents unchanged, so reading it again returns the same word.
- R6: With bus size `2'b00`, all 36 bits pass unchanged.
- R7: With bus size `2'b01`, only bits 0 to 17 pass. Bits 18 to 35 are ignored on input and read as zero.
- R8: With bus size `2'b10` or `2'b11`, only bits 0 to 8 pass. Bits 9 to 35 are ignored on input and read as zero.
- R9: The byte-order input does not change mailbox data.
- R10: A write happens only when select is LOW, direction is 1, enable is HIGH and mailbox-select is HIGH. Otherwise the register and the reader's flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| bus_size | input | 2 | Usable width: 00 = 36 bits, 01 = 18 bits, 1x = 9 bits |
| order_sel | input | 1 | Byte-order choice, ignored by mailboxes |
| a_sel_n | input | 1 | Port A select, active low |
| a_write | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mbox | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A read data (second register) |
| a_mail_full_n | output | 1 | LOW when the second register holds an unread word |
| b_sel_n | input | 1 | Port B select, active low |
| b_write | input | 1 | Port B direction, 1 = write |
| b_en | input | 1 | Port B enable |
| b_mbox | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B read data (first register) |
| b_mail_full_n | output | 1 | LOW when the first register holds an unread word |

## Verification
The assertions inside the channel check on every cycle that:
- a write while full leaves the stored word untouched;
- the stored word changes only after an accepted write;
- the read-side toggle moves only on a read;
- narrowed reads return zero in the upper lanes.

Only the bench scenarios can show the end-to-end handover across the ports. That covers flag timing as seen at the pins, the qualifier combinations that must do nothing, repeated reads returning the same word, and the byte-order input having no effect.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   // Usable-width setting shared by both ports
   typedef enum logic [1:0] {
      BUS_LONG     = 2'b00,
      BUS_WORD     = 2'b01,
      BUS_BYTE     = 2'b10,
      BUS_BYTE_ALT = 2'b11
   } bus_size_e;

endpackage

// File: rtl/mbox_lane_mask.sv
module mbox_lane_mask
   import mbox_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DW    = LANE_W * LANES
) (
   input  bus_size_e         size,
   output logic [DW-1:0]     mask
);

   localparam int WORD_LANES = LANES / 2;

   generate
      if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
         $error("mbox_lane_mask: LANES must be even and at least 2");
      end
      if (LANE_W < 1) begin : g_bad_width
         $error("mbox_lane_mask: LANE_W must be positive");
      end
   endgenerate

   int live;

   always_comb begin
      case (size)
         BUS_LONG: live = LANES;
         BUS_WORD: live = WORD_LANES;
         default:  live = 1;
      endcase
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign mask[g*LANE_W +: LANE_W] = {LANE_W{(g < live)}};
      end
   endgenerate

endmodule

// File: rtl/mbox_decode.sv
module mbox_decode (
   input  logic sel_n,
   input  logic write,
   input  logic en,
   input  logic mbox,
   output logic rd_go,
   output logic wr_go
);

   logic hit;

   assign hit   = ~sel_n & en & mbox;
   assign rd_go = hit & ~write;
   assign wr_go = hit & write;

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
   import mbox_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DW    = LANE_W * LANES,
   localparam int HALF  = (LANES / 2) * LANE_W
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          wr_go,
   input  logic          rd_go,
   input  bus_size_e     wsize,
   input  bus_size_e     rsize,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          full_n
);

   logic [DW-1:0] wmask, rmask;
   logic [DW-1:0] store_q, rdata_q;
   logic          wtog_q, rtog_q;
   logic          full;
   logic          take_wr;

   mbox_lane_mask #(.LANE_W(LANE_W), .LANES(LANES)) u_wmask (.size(wsize), .mask(wmask));
   mbox_lane_mask #(.LANE_W(LANE_W), .LANES(LANES)) u_rmask (.size(rsize), .mask(rmask));

   // occupancy is the difference of two single-domain toggles
   assign full    = wtog_q ^ rtog_q;
   assign full_n  = ~full;
   assign take_wr = wr_go & ~full;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
         wtog_q  <= 1'b0;
      end else if (take_wr) begin
         store_q <= wdata & wmask;
         wtog_q  <= ~wtog_q;
      end
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rtog_q  <= 1'b0;
      end else if (rd_go) begin
         rdata_q <= store_q & rmask;
         if (full) rtog_q <= ~rtog_q;
      end
   end

   assign rdata = rdata_q;

   // R4
   ign_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_go && !full_n) |=> $stable(store_q));

   // R5
   store_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !$stable(store_q) |-> $past(wr_go));

   // R3
   rd_toggle_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      !$stable(rtog_q) |-> $past(rd_go));

   // R7
   word_lane_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      (rd_go && rsize != BUS_LONG) |=> (rdata_q[DW-1:HALF] == '0));

   // R8
   byte_lane_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      (rd_go && (rsize == BUS_BYTE || rsize == BUS_BYTE_ALT)) |=> (rdata_q[DW-1:LANE_W] == '0));

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
   import mbox_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DW    = LANE_W * LANES
) (
   input  logic          clk_a,
   input  logic          clk_b,
   input  logic          rst_n,
   input  logic [1:0]    bus_size,
   input  logic          order_sel,
   input  logic          a_sel_n,
   input  logic          a_write,
   input  logic          a_en,
   input  logic          a_mbox,
   input  logic [DW-1:0] a_din,
   output logic [DW-1:0] a_dout,
   output logic          a_mail_full_n,
   input  logic          b_sel_n,
   input  logic          b_write,
   input  logic          b_en,
   input  logic          b_mbox,
   input  logic [DW-1:0] b_din,
   output logic [DW-1:0] b_dout,
   output logic          b_mail_full_n
);

   logic      a_rd, a_wr, b_rd, b_wr;
   bus_size_e size_e;
   logic      unused_order;

   assign size_e       = bus_size_e'(bus_size);
   assign unused_order = order_sel;

   mbox_decode u_dec_a (.sel_n(a_sel_n), .write(a_write), .en(a_en), .mbox(a_mbox),
                        .rd_go(a_rd), .wr_go(a_wr));
   mbox_decode u_dec_b (.sel_n(b_sel_n), .write(b_write), .en(b_en), .mbox(b_mbox),
                        .rd_go(b_rd), .wr_go(b_wr));

   // first register: A writes, B reads
   mbox_channel #(.LANE_W(LANE_W), .LANES(LANES)) u_a2b (
      .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
      .wr_go(a_wr), .rd_go(b_rd), .wsize(size_e), .rsize(size_e),
      .wdata(a_din), .rdata(b_dout), .full_n(b_mail_full_n));

   // second register: B writes, A reads
   mbox_channel #(.LANE_W(LANE_W), .LANES(LANES)) u_b2a (
      .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
      .wr_go(b_wr), .rd_go(a_rd), .wsize(size_e), .rsize(size_e),
      .wdata(b_din), .rdata(a_dout), .full_n(a_mail_full_n));

endmodule

// File: tb/mbox_pair_test.sv
`timescale 1ns/1ps
module mbox_pair_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  bus_size;
   logic        order_sel;
   logic        a_sel_n, a_write, a_en, a_mbox;
   logic [35:0] a_din, a_dout;
   logic        a_mail_full_n;
   logic        b_sel_n, b_write, b_en, b_mbox;
   logic [35:0] b_din, b_dout;
   logic        b_mail_full_n;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [35:0] qa_data[$];
   string       qa_tag[$];
   logic [35:0] qb_data[$];
   string       qb_tag[$];
   logic        a_rd_seen = 1'b0, b_rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   mbox_pair uut (
      .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
      .bus_size(bus_size), .order_sel(order_sel),
      .a_sel_n(a_sel_n), .a_write(a_write), .a_en(a_en), .a_mbox(a_mbox),
      .a_din(a_din), .a_dout(a_dout), .a_mail_full_n(a_mail_full_n),
      .b_sel_n(b_sel_n), .b_write(b_write), .b_en(b_en), .b_mbox(b_mbox),
      .b_din(b_din), .b_dout(b_dout), .b_mail_full_n(b_mail_full_n));

   task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pop and compare every qualified read one half cycle after its edge
   always @(posedge clk) begin
      a_rd_seen <= !a_sel_n && !a_write && a_en && a_mbox;
      b_rd_seen <= !b_sel_n && !b_write && b_en && b_mbox;
   end

   always @(negedge clk) begin
      if (a_rd_seen) begin
         if (qa_data.size() == 0) check(0, "scoreboard A unexpected read", a_dout, '0);
         else begin
            logic [35:0] e;
            string t;
            e = qa_data.pop_front();
            t = qa_tag.pop_front();
            check(a_dout === e, t, a_dout, e);
         end
      end
      if (b_rd_seen) begin
         if (qb_data.size() == 0) check(0, "scoreboard B unexpected read", b_dout, '0);
         else begin
            logic [35:0] e;
            string t;
            e = qb_data.pop_front();
            t = qb_tag.pop_front();
            check(b_dout === e, t, b_dout, e);
         end
      end
   end

   task automatic a_drive(input logic sel_n, input logic wr, input logic en, input logic mb, input logic [35:0] d);
      a_sel_n = sel_n; a_write = wr; a_en = en; a_mbox = mb; a_din = d;
      @(negedge clk);
      a_sel_n = 1'b1; a_en = 1'b0;
   endtask

   task automatic b_drive(input logic sel_n, input logic wr, input logic en, input logic mb, input logic [35:0] d);
      b_sel_n = sel_n; b_write = wr; b_en = en; b_mbox = mb; b_din = d;
      @(negedge clk);
      b_sel_n = 1'b1; b_en = 1'b0;
   endtask

   task automatic a_read_exp(input logic [35:0] e, input string t);
      qa_data.push_back(e); qa_tag.push_back(t);
      a_drive(1'b0, 1'b0, 1'b1, 1'b1, '0);
   endtask

   task automatic b_read_exp(input logic [35:0] e, input string t);
      qb_data.push_back(e); qb_tag.push_back(t);
      b_drive(1'b0, 1'b0, 1'b1, 1'b1, '0);
   endtask

   initial begin
      #(5.0 * 50000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_size = 2'b00; order_sel = 1'b0;
      a_sel_n = 1'b1; a_write = 1'b0; a_en = 1'b0; a_mbox = 1'b0; a_din = '0;
      b_sel_n = 1'b1; b_write = 1'b0; b_en = 1'b0; b_mbox = 1'b0; b_din = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(a_dout === '0, "R1 a_dout", a_dout, '0);
      check(b_dout === '0, "R1 b_dout", b_dout, '0);
      check(a_mail_full_n === 1'b1, "R1 a flag", {35'b0, a_mail_full_n}, 36'h1);
      check(b_mail_full_n === 1'b1, "R1 b flag", {35'b0, b_mail_full_n}, 36'h1);

      // R2 R6 A to B full width
      a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'h9_8765_4321);
      check(b_mail_full_n === 1'b0, "R2 b flag after write", {35'b0, b_mail_full_n}, 36'h0);
      check(a_mail_full_n === 1'b1, "R2 a flag untouched", {35'b0, a_mail_full_n}, 36'h1);
      b_read_exp(36'h9_8765_4321, "R6 full width A to B");
      check(b_mail_full_n === 1'b1, "R3 b flag after read", {35'b0, b_mail_full_n}, 36'h1);

      // R5 repeated read
      b_read_exp(36'h9_8765_4321, "R5 second read same word");

      // R4 write while full ignored
      a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'hA_5A5A_5A5A);
      a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'h1_2345_6789);
      b_read_exp(36'hA_5A5A_5A5A, "R4 first word kept");

      // R2 R3 B to A
      b_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'hC_0FFE_E123);
      check(a_mail_full_n === 1'b0, "R2 a flag after write", {35'b0, a_mail_full_n}, 36'h0);
      a_read_exp(36'hC_0FFE_E123, "R6 full width B to A");
      check(a_mail_full_n === 1'b1, "R3 a flag after read", {35'b0, a_mail_full_n}, 36'h1);

      // R3 read qualifiers missing
      a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'h3_3333_3333);
      b_drive(1'b0, 1'b0, 1'b0, 1'b1, '0);
      check(b_dout === 36'hA_5A5A_5A5A, "R3 no read without enable", b_dout, 36'hA_5A5A_5A5A);
      b_drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
      check(b_dout === 36'hA_5A5A_5A5A, "R3 no read without mailbox select", b_dout, 36'hA_5A5A_5A5A);
      b_drive(1'b1, 1'b0, 1'b1, 1'b1, '0);
      check(b_dout === 36'hA_5A5A_5A5A, "R3 no read without select", b_dout, 36'hA_5A5A_5A5A);
      check(b_mail_full_n === 1'b0, "R3 flag kept low", {35'b0, b_mail_full_n}, 36'h0);
      b_read_exp(36'h3_3333_3333, "R3 qualified read");

      // R10 write qualifiers missing
      a_drive(1'b0, 1'b1, 1'b1, 1'b0, 36'hE_EEEE_EEEE);
      check(b_mail_full_n === 1'b1, "R10 no write without mailbox select", {35'b0, b_mail_full_n}, 36'h1);
      a_drive(1'b0, 1'b1, 1'b0, 1'b1, 36'hE_EEEE_EEEE);
      check(b_mail_full_n === 1'b1, "R10 no write without enable", {35'b0, b_mail_full_n}, 36'h1);
      a_drive(1'b1, 1'b1, 1'b1, 1'b1, 36'hE_EEEE_EEEE);
      check(b_mail_full_n === 1'b1, "R10 no write without select", {35'b0, b_mail_full_n}, 36'h1);
      b_read_exp(36'h3_3333_3333, "R10 register unchanged");

      // R7 18-bit size
      bus_size = 2'b01;
      a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'hF_FFFF_FFFF);
      b_read_exp(36'h0_0003_FFFF, "R7 A to B 18 bits");
      b_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'hF_FFF0_1234);
      a_read_exp(36'h0_0000_1234, "R7 B to A 18 bits");

      // R8 9-bit size
      bus_size = 2'b10;
      a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'hF_FFFF_FFFF);
      b_read_exp(36'h0_0000_01FF, "R8 A to B 9 bits");
      bus_size = 2'b11;
      b_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'hA_BCDE_F1AB);
      a_read_exp(36'h0_0000_01AB, "R8 B to A 9 bits alt code");

      // R9 byte order ignored
      order_sel = 1'b1;
      bus_size  = 2'b01;
      a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'h5_6789_ABCD);
      b_read_exp(36'h0_0001_ABCD, "R9 order ignored 18 bits");
      bus_size = 2'b00;
      b_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'h1_2345_6789);
      a_read_exp(36'h1_2345_6789, "R9 order ignored 36 bits");

      @(negedge clk);
      check(qa_data.size() == 0 && qb_data.size() == 0, "scoreboard drained",
            36'(qa_data.size() + qb_data.size()), '0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule